// File: doc/BRIEF.md
# Residue-to-Mixed-Radix Converter

This block takes an operand held as four residues over the fixed coprime base {27, 29, 31, 32} and produces its mixed-radix digits. The operand range is the product of the moduli, 776736. The operand is an integer X in [0, 776736). It is rebuilt from the digits as X = d1 + d2·27 + d3·783 + d4·24273, where each digit dj lies in [0, mj). The operand carries its sign implicitly. It is taken as negative when it falls in the upper half of the range, and this half is read directly from the most significant digit.

The conversion runs as a chain of three registered stages. At stage k, the digit just settled is subtracted from every channel that is still unresolved. Each difference goes through a 6-bit two's-complement adder. A 64-entry table then maps the difference to the product of the difference, reduced into the channel's ring, and the inverse of the stage's modulus. The tables are computed while the design elaborates. Channels that are already resolved ride along unchanged. A new operand may enter on every clock cycle.

The reset input is asynchronous and active low. It is expected to be deasserted in step with the clock.

Top module: `rmx_conv`

## Requirements
- R1: While reset is held, out_vld, out_dig and out_neg are all zero.
- R2: out_vld equals in_vld as sampled three rising edges earlier, and it is high for exactly one cycle per accepted operand.
- R3: The lowest digit (out_dig bits [4:0]) equals the channel-27 residue (in_res bits [4:0]) of the same operand.
- R4: Each output digit j lies below its modulus: bits [4:0] < 27, bits [9:5] < 29, bits [14:10] < 31, bits [19:15] < 32.
- R5: For an operand X with in_res fields {X mod 32, X mod 31, X mod 29, X mod 27} (bits [19:15] down to [4:0]), out_dig fields are {X/24273, (X/783) mod 31, (X/27) mod 29, X mod 27}, in the same field order.
- R6: out_neg is 1 exactly when the top digit is 16 or more. Operand 388367 therefore reads non-negative and operand 388368 reads negative.
- R7: While out_vld is low, out_dig and out_neg keep their last values, whatever in_res carries while in_vld is low.
- R8: Operands presented on consecutive cycles all come out, one per cycle, in the order they were presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand strobe |
| in_res | input | 20 | Four 5-bit residues; channel 27 in the lowest field, channel 32 in the highest |
| out_vld | output | 1 | Digit strobe, three cycles after in_vld |
| out_dig | output | 20 | Four 5-bit mixed-radix digits; lowest-weight digit in the lowest field |
| out_neg | output | 1 | Operand lies in the upper half of the range |

## Verification
The properties assume that every residue presented with in_vld is already reduced, so each field is below its own modulus. An unreduced value in the channels for 27, 29 or 31 would break the reconstruction property. This assumption holds by construction in the stimulus, because every input word is formed by taking an integer operand modulo each channel. The operands cover an exhaustive run over the lowest 4096 values, a strided walk across the whole range with bubbles inserted, and the values next to each weight and next to the sign boundary.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

  localparam int unsigned RW  = 5;
  localparam int unsigned NCH = 4;

  typedef int unsigned base_t [NCH];
  localparam base_t BASE = '{27, 29, 31, 32};

  // Interpret a BITS-wide code as two's complement.
  function automatic int as_signed(input int code, input int bits);
    int r;
    r = code;
    if (code >= (1 << (bits - 1))) r = code - (1 << bits);
    return r;
  endfunction

  // Multiplicative inverse of a modulo m, found by search (m is small).
  function automatic int mod_inv(input int a, input int m);
    int r;
    r = 0;
    for (int k = 1; k < m; k++) begin
      if (r == 0 && ((a % m) * k) % m == 1) r = k;
    end
    return r;
  endfunction

  // Table entry: signed difference code -> (diff mod m) * inv mod m.
  function automatic int lut_val(input int code, input int bits,
                                 input int m, input int inv);
    int d;
    d = as_signed(code, bits) % m;
    if (d < 0) d = d + m;
    return (d * inv) % m;
  endfunction

endpackage

// File: rtl/rmx_lut.sv
module rmx_lut #(
  parameter int unsigned W    = 5,
  parameter int unsigned MODV = 29,
  parameter int unsigned INV  = 14
) (
  input  logic [W-1:0] minu,
  input  logic [W-1:0] subt,
  output logic [W-1:0] res
);
  localparam int unsigned DW   = W + 1;
  localparam int unsigned TLEN = 1 << DW;

  logic [DW-1:0] diff;
  logic [W-1:0]  tbl [TLEN];

  assign diff = {1'b0, minu} - {1'b0, subt};

  for (genvar i = 0; i < TLEN; i++) begin : g_tbl
    assign tbl[i] = W'(rmx_pkg::lut_val(i, DW, MODV, INV));
  end

  assign res = tbl[diff];
endmodule

// File: rtl/rmx_stage.sv
module rmx_stage #(
  parameter int unsigned K = 0,
  parameter int unsigned N = rmx_pkg::NCH,
  parameter int unsigned W = rmx_pkg::RW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vld_i,
  input  logic [N*W-1:0] dig_i,
  output logic           vld_o,
  output logic [N*W-1:0] dig_o
);
  logic [N*W-1:0] dig_nxt;
  logic           vld_nxt;
  logic           dig_en;

  for (genvar j = 0; j < N; j++) begin : g_ch
    if (j > K) begin : g_red
      rmx_lut #(
        .W   (W),
        .MODV(rmx_pkg::BASE[j]),
        .INV (rmx_pkg::mod_inv(rmx_pkg::BASE[K], rmx_pkg::BASE[j]))
      ) u_lut (
        .minu(dig_i[j*W +: W]),
        .subt(dig_i[K*W +: W]),
        .res (dig_nxt[j*W +: W])
      );
    end else begin : g_pass
      assign dig_nxt[j*W +: W] = dig_i[j*W +: W];
    end
  end

  always_comb begin
    vld_nxt = vld_i;
    dig_en  = vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      dig_o <= '0;
    end else begin
      vld_o <= vld_nxt;
      if (dig_en) dig_o <= dig_nxt;
    end
  end
endmodule

// File: rtl/rmx_conv.sv
module rmx_conv #(
  parameter int unsigned W = rmx_pkg::RW,
  parameter int unsigned N = rmx_pkg::NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [N*W-1:0] in_res,
  output logic           out_vld,
  output logic [N*W-1:0] out_dig,
  output logic           out_neg
);
  localparam int unsigned NST  = N - 1;
  localparam int unsigned HALF = rmx_pkg::BASE[N-1] / 2;

  logic [N*W-1:0] dig [N];
  logic           vld [N];

  assign dig[0] = in_res;
  assign vld[0] = in_vld;

  for (genvar k = 0; k < NST; k++) begin : g_stg
    rmx_stage #(.K(k), .N(N), .W(W)) u_stg (
      .clk  (clk),
      .rst_n(rst_n),
      .vld_i(vld[k]),
      .dig_i(dig[k]),
      .vld_o(vld[k+1]),
      .dig_o(dig[k+1])
    );
  end

  assign out_vld = vld[NST];
  assign out_dig = dig[NST];
  assign out_neg = (out_dig[(N-1)*W +: W] >= W'(HALF));
endmodule

// File: rtl/rmx_conv_chk.sv
module rmx_conv_chk #(
  parameter int unsigned W = rmx_pkg::RW,
  parameter int unsigned N = rmx_pkg::NCH
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_vld,
  input logic [N*W-1:0] in_res,
  input logic           out_vld,
  input logic [N*W-1:0] out_dig,
  input logic           out_neg
);
  logic [1:0]  cyc;
  int unsigned wsum;
  int unsigned wgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always_comb begin
    wsum = 0;
    wgt  = 1;
    for (int j = 0; j < N; j++) begin
      wsum = wsum + 32'(out_dig[j*W +: W]) * wgt;
      wgt  = wgt * rmx_pkg::BASE[j];
    end
  end

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_vld == $past(in_vld, 3)));

  // R3
  low_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && out_vld) |-> (out_dig[W-1:0] == $past(in_res[W-1:0], 3)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && !out_vld) |-> ($stable(out_dig) && $stable(out_neg)));

  for (genvar j = 0; j < N; j++) begin : g_a
    // R4
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (32'(out_dig[j*W +: W]) < rmx_pkg::BASE[j]));

    // R5
    recon_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && out_vld) |->
        ((wsum % rmx_pkg::BASE[j]) == 32'($past(in_res[j*W +: W], 3))));
  end

  logic unused_neg;
  assign unused_neg = out_neg;
endmodule

bind rmx_conv rmx_conv_chk #(.W(W), .N(N)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .in_vld (in_vld),
  .in_res (in_res),
  .out_vld(out_vld),
  .out_dig(out_dig),
  .out_neg(out_neg)
);

// File: tb/rmx_conv_tb.sv
module rmx_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MTOT = 776736;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [19:0] in_res = '0;
  logic        out_vld;
  logic [19:0] out_dig;
  logic        out_neg;

  int n_chk = 0;
  int n_bad = 0;
  int sent = 0;
  int rcvd = 0;
  int mon_x;
  bit done = 1'b0;
  int pend[$];
  logic [19:0] hold_dig;
  logic        hold_neg;

  rmx_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_res(in_res),
    .out_vld(out_vld), .out_dig(out_dig), .out_neg(out_neg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [19:0] to_res(input int x);
    return {5'(x % 32), 5'(x % 31), 5'(x % 29), 5'(x % 27)};
  endfunction

  function automatic logic [19:0] to_dig(input int x);
    return {5'(x / 24273), 5'((x / 783) % 31), 5'((x / 27) % 29), 5'(x % 27)};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(input int x, input bit v);
    @(negedge clk);
    in_vld = v;
    in_res = to_res(x);
    if (v) begin
      pend.push_back(x);
      sent++;
    end
  endtask

  // Scoreboard: R3, R4, R5, R6 on every output word
  always @(negedge clk) begin
    if (rst_n && out_vld && !done) begin
      if (pend.size() == 0) begin
        chk(1'b0, "R2", "output with nothing pending", 1, 0);
      end else begin
        mon_x = pend.pop_front();
        rcvd++;
        chk(out_dig == to_dig(mon_x), "R4/R5", "digits", int'(out_dig), int'(to_dig(mon_x)));
        chk(out_dig[4:0] == 5'(mon_x % 27), "R3", "low digit", int'(out_dig[4:0]), mon_x % 27);
        chk(out_neg == (mon_x >= MTOT/2), "R6", "sign", int'(out_neg), int'(mon_x >= MTOT/2));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_vld == 1'b0, "R1", "out_vld in reset", int'(out_vld), 0);
    chk(out_dig == '0, "R1", "out_dig in reset", int'(out_dig), 0);
    chk(out_neg == 1'b0, "R1", "out_neg in reset", int'(out_neg), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: single operand, three-cycle latency, one-cycle strobe
    send(123456, 1'b1);
    send(0, 1'b0);
    chk(!out_vld, "R2", "strobe after 1 edge", int'(out_vld), 0);
    @(negedge clk);
    chk(!out_vld, "R2", "strobe after 2 edges", int'(out_vld), 0);
    @(negedge clk);
    chk(out_vld, "R2", "strobe after 3 edges", int'(out_vld), 1);
    @(negedge clk);
    chk(!out_vld, "R2", "strobe after 4 edges", int'(out_vld), 0);

    // Corners: digit weights and the sign boundary (R6)
    begin
      int corners [12] = '{0, 1, 26, 27, 782, 783, 24272, 24273,
                           MTOT/2 - 1, MTOT/2, MTOT/2 + 1, MTOT - 1};
      foreach (corners[i]) begin
        send(corners[i], 1'b1);
        if (i % 2 == 1) send(0, 1'b0);
      end
    end

    // R8: back-to-back exhaustive low range
    for (int k = 0; k < 4096; k++) send(k, 1'b1);

    // Strided walk over the full range with bubbles
    for (int k = 0; k < 20000; k++)
      send((k * 38837 + 12345) % MTOT, (k % 7) != 3);

    repeat (6) send(0, 1'b0);
    chk(sent == rcvd, "R8", "outputs received", rcvd, sent);

    // R7: inputs change with in_vld low, outputs must hold
    hold_dig = out_dig;
    hold_neg = out_neg;
    for (int i = 1; i <= 6; i++) begin
      send((i * 99991) % MTOT, 1'b0);
      chk(out_dig == hold_dig && out_neg == hold_neg && !out_vld, "R7",
          "outputs held", int'(out_dig), int'(hold_dig));
    end
    repeat (3) @(negedge clk);
    chk(out_dig == hold_dig && !out_vld, "R7", "outputs held after drain",
        int'(out_dig), int'(hold_dig));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule